// File: doc/BRIEF.md
# Twin-Predicated Element Move Sequencer

This block drives two-operand copy operations across a span of register elements. It keeps two separate element indices, one for the source and one for the destination. Each index moves forward under its own predicate mask. On every active cycle it issues one element copy as a pair of addresses: a read address (source base plus source index) and a write address (destination base plus destination index). A small register file placed beside it performs the actual move.

Each side is tagged as either vector or scalar. A vector side steps over the elements whose predicate bit is clear. A scalar side stays on its base register, and its predicate is ignored. Setting the two tags and masks in different ways makes one sequencer serve for broadcast, sparse broadcast, single-element insert and extract, gather, scatter, gather-scatter and plain vector copy. The current indices are brought out on every step as saved-context offsets, so that an interrupted operation can be resumed.

A one-cycle start pulse captures every operand. A one-cycle done pulse marks the end. All pins are plain control and status. There is no data stream and no back-pressure: the register file is assumed to accept one copy on every cycle in which the write enable is high.

Top module: `twin_pred_mover`

## Requirements
- R1: After reset, wr_en and done are 0 and both offset outputs are 0.
- R2: On a vector-tagged side, each copy uses the lowest element at or above the current index whose predicate bit (bit k of the mask predicates element k) is 1. On a scalar-tagged side the index stays at 0 and the mask has no effect.
- R3: Each copy reads rd_addr = src_base + i and writes wr_addr = dst_base + j, with the sums wrapping modulo 2^AW.
- R4: When the destination is scalar, the operation ends after at most one copy. With a vector source, that copy takes the first predicated source element (extract).
- R5: A scalar source with a vector destination whose mask is all ones issues exactly VL copies, all reading the same source register (broadcast).
- R6: If either index search reaches VL without finding a usable element, the operation ends without a write. VL = 0 produces no write.
- R7: done is high for exactly one cycle per operation, after its last copy, and wr_en is 0 in that cycle.
- R8: Operands are captured on the cycle start is accepted. Later changes to them, and start pulses that arrive while an operation is running, have no effect.
- R9: On every copy, src_offs and dst_offs equal the element indices i and j used for that copy.
- R10: Copies are issued one per cycle, back to back, starting in the first cycle after start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| src_base | input | AW | Source base register number |
| dst_base | input | AW | Destination base register number |
| src_vec | input | 1 | Source side is a vector |
| dst_vec | input | 1 | Destination side is a vector |
| src_pred | input | MAX_VL | Source predicate mask |
| dst_pred | input | MAX_VL | Destination predicate mask |
| vl | input | IW | Element count of the operation |
| rd_addr | output | AW | Register read address of the current copy |
| wr_addr | output | AW | Register write address of the current copy |
| wr_en | output | 1 | A copy is issued in this cycle |
| src_offs | output | IW | Saved-context source index |
| dst_offs | output | IW | Saved-context destination index |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The main function is tried on every combination of the two tags. Full masks separate index stepping from skipping. Sparse source-only, destination-only and two-sided masks show whether each side skips on its own mask and whether the two indices are kept independent. Patterns whose only set bit lies at or above VL, an empty mask and VL = 0 separate termination without a write from a spurious copy. A wrapping base checks the address sums, and a scalar side carrying a junk mask shows that scalar masks are ignored.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tpm_state_t;
endpackage

// File: rtl/tpm_skip_enc.sv
// Finds the next usable element index at or above pos. A scalar side keeps pos.
module tpm_skip_enc #(
  parameter int N  = 8,
  parameter int IW = $clog2(N + 1)
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] pos,
  input  logic          is_vec,
  output logic [IW-1:0] idx
);
  always_comb begin
    if (!is_vec) begin
      idx = pos;
    end else begin
      idx = IW'(N);
      for (int k = N - 1; k >= 0; k--) begin
        if (mask[k] && (k >= int'(pos))) idx = IW'(k);
      end
    end
  end
endmodule

// File: rtl/tpm_addr_gen.sv
// Register number = base + element offset, wrapped to the address width.
module tpm_addr_gen #(
  parameter int AW = 5,
  parameter int IW = 4
) (
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] offs,
  output logic [AW-1:0] addr
);
  logic [AW+IW-1:0] sum;
  assign sum  = {{IW{1'b0}}, base} + {{AW{1'b0}}, offs};
  assign addr = sum[AW-1:0];
endmodule

// File: rtl/twin_pred_mover.sv
module twin_pred_mover #(
  parameter int MAX_VL = 8,
  parameter int AW     = 5,
  localparam int IW    = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     src_base,
  input  logic [AW-1:0]     dst_base,
  input  logic              src_vec,
  input  logic              dst_vec,
  input  logic [MAX_VL-1:0] src_pred,
  input  logic [MAX_VL-1:0] dst_pred,
  input  logic [IW-1:0]     vl,
  output logic [AW-1:0]     rd_addr,
  output logic [AW-1:0]     wr_addr,
  output logic              wr_en,
  output logic [IW-1:0]     src_offs,
  output logic [IW-1:0]     dst_offs,
  output logic              done
);
  import tpm_pkg::*;

  tpm_state_t        state_q;
  logic [AW-1:0]     sbase_q, dbase_q;
  logic              svec_q, dvec_q;
  logic [MAX_VL-1:0] smask_q, dmask_q;
  logic [IW-1:0]     vl_q;
  logic [IW-1:0]     i_q, j_q;
  logic              done_q;

  logic [IW-1:0]     i_hit, j_hit;
  logic              running, step_ok, finish;

  // Per-side skip search, one cycle each
  tpm_skip_enc #(.N(MAX_VL), .IW(IW)) u_src_skip (
    .mask(smask_q), .pos(i_q), .is_vec(svec_q), .idx(i_hit)
  );
  tpm_skip_enc #(.N(MAX_VL), .IW(IW)) u_dst_skip (
    .mask(dmask_q), .pos(j_q), .is_vec(dvec_q), .idx(j_hit)
  );

  tpm_addr_gen #(.AW(AW), .IW(IW)) u_rd_addr (
    .base(sbase_q), .offs(i_hit), .addr(rd_addr)
  );
  tpm_addr_gen #(.AW(AW), .IW(IW)) u_wr_addr (
    .base(dbase_q), .offs(j_hit), .addr(wr_addr)
  );

  assign running  = (state_q == ST_RUN);
  assign step_ok  = (i_hit < vl_q) && (j_hit < vl_q);
  assign wr_en    = running && step_ok;
  // Ends when a search runs out, or after the single copy to a scalar target
  assign finish   = running && (!step_ok || !dvec_q);
  assign src_offs = running ? i_hit : i_q;
  assign dst_offs = running ? j_hit : j_q;
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sbase_q <= '0;
      dbase_q <= '0;
      svec_q  <= 1'b0;
      dvec_q  <= 1'b0;
      smask_q <= '0;
      dmask_q <= '0;
      vl_q    <= '0;
      i_q     <= '0;
      j_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (!running) begin
        if (start) begin
          state_q <= ST_RUN;
          sbase_q <= src_base;
          dbase_q <= dst_base;
          svec_q  <= src_vec;
          dvec_q  <= dst_vec;
          smask_q <= src_pred;
          dmask_q <= dst_pred;
          vl_q    <= (vl > IW'(MAX_VL)) ? IW'(MAX_VL) : vl;
          i_q     <= '0;
          j_q     <= '0;
        end
      end else begin
        if (finish) state_q <= ST_IDLE;
        if (step_ok) begin
          i_q <= svec_q ? i_hit + IW'(1) : i_hit;
          j_q <= dvec_q ? j_hit + IW'(1) : j_hit;
        end
      end
    end
  end

  // A vector source copy lands on a predicated element
  p_src_pred_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && svec_q) |-> smask_q[src_offs]);
  p_dst_pred_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dvec_q) |-> dmask_q[dst_offs]);
  p_scalar_dst_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !dvec_q) |=> !wr_en);
  p_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((src_offs < vl_q) && (dst_offs < vl_q)));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);
  p_src_forward_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && svec_q) |=> (!wr_en || (src_offs > $past(src_offs))));
  p_dst_forward_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dvec_q) |=> (!wr_en || (dst_offs > $past(dst_offs))));
endmodule

// File: tb/test_twin_pred_mover.sv
module test_twin_pred_mover;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_VL = 8;
  localparam int AW = 5;
  localparam int IW = $clog2(MAX_VL + 1);

  typedef struct packed {
    logic [4:0] sb;
    logic [4:0] db;
    logic       sv;
    logic       dv;
    logic [7:0] sm;
    logic [7:0] dm;
    logic [3:0] vl;
    logic [3:0] n;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{5'd0,  5'd16, 1'b1, 1'b1, 8'hFF,       8'hFF,       4'd8, 4'd8}, // copy
    '{5'd3,  5'd8,  1'b0, 1'b1, 8'h00,       8'hFF,       4'd5, 4'd5}, // broadcast
    '{5'd3,  5'd8,  1'b0, 1'b1, 8'h5A,       8'b10100101, 4'd8, 4'd4}, // sparse broadcast
    '{5'd1,  5'd20, 1'b1, 1'b1, 8'b01011000, 8'hFF,       4'd8, 4'd3}, // gather
    '{5'd1,  5'd20, 1'b1, 1'b1, 8'hFF,       8'b00010010, 4'd8, 4'd2}, // scatter
    '{5'd4,  5'd12, 1'b1, 1'b1, 8'b11000001, 8'b00101010, 4'd8, 4'd3}, // gather-scatter
    '{5'd2,  5'd9,  1'b1, 1'b0, 8'b00100000, 8'h00,       4'd8, 4'd1}, // extract
    '{5'd6,  5'd10, 1'b0, 1'b1, 8'h00,       8'b00001000, 4'd8, 4'd1}, // insert
    '{5'd7,  5'd11, 1'b0, 1'b0, 8'h00,       8'h00,       4'd4, 4'd1}, // scalar-scalar
    '{5'd0,  5'd0,  1'b1, 1'b1, 8'hFF,       8'hFF,       4'd0, 4'd0}, // vl zero
    '{5'd0,  5'd8,  1'b1, 1'b1, 8'h00,       8'hFF,       4'd8, 4'd0}, // empty source
    '{5'd30, 5'd28, 1'b1, 1'b1, 8'hFF,       8'hFF,       4'd6, 4'd6}, // wrap
    '{5'd0,  5'd8,  1'b1, 1'b1, 8'hFF,       8'hFF,       4'd3, 4'd3}, // vl cut
    '{5'd0,  5'd8,  1'b1, 1'b0, 8'b10000000, 8'h00,       4'd6, 4'd0}  // bit past vl
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [AW-1:0]     src_base = '0, dst_base = '0;
  logic              src_vec = 1'b0, dst_vec = 1'b0;
  logic [MAX_VL-1:0] src_pred = '0, dst_pred = '0;
  logic [IW-1:0]     vl = '0;
  logic [AW-1:0]     rd_addr, wr_addr;
  logic              wr_en, done;
  logic [IW-1:0]     src_offs, dst_offs;

  int tests = 0;
  int fails = 0;
  int exp_i [MAX_VL];
  int exp_j [MAX_VL];
  int exp_n;

  always #(CLK_PERIOD / 2) clk = ~clk;

  twin_pred_mover #(.MAX_VL(MAX_VL), .AW(AW)) i_twin_pred_mover (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_base(src_base), .dst_base(dst_base),
    .src_vec(src_vec), .dst_vec(dst_vec),
    .src_pred(src_pred), .dst_pred(dst_pred), .vl(vl),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .wr_en(wr_en),
    .src_offs(src_offs), .dst_offs(dst_offs), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Expected element pairs from the requirements
  task automatic model(input vec_t v);
    int i = 0;
    int j = 0;
    exp_n = 0;
    forever begin
      if (v.sv) while (i < int'(v.vl) && !v.sm[i]) i++;
      if (v.dv) while (j < int'(v.vl) && !v.dm[j]) j++;
      if (i >= int'(v.vl) || j >= int'(v.vl)) break;
      exp_i[exp_n] = i;
      exp_j[exp_n] = j;
      exp_n++;
      if (v.sv) i++;
      if (v.dv) j++;
      else break;
    end
  endtask

  task automatic drive(input vec_t v);
    src_base = v.sb; dst_base = v.db;
    src_vec = v.sv;  dst_vec = v.dv;
    src_pred = v.sm; dst_pred = v.dm;
    vl = IW'(v.vl);
  endtask

  // mode 0: plain, 1: operands changed after start, 2: extra start while running
  task automatic run_op(input vec_t v, input int mode);
    int n = 0;
    int dones = 0;
    model(v);
    chk(exp_n == int'(v.n), "R2 model count", exp_n, int'(v.n));
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mode == 1) begin
      src_base = ~v.sb; dst_base = ~v.db; src_pred = ~v.sm;
      dst_pred = ~v.dm; src_vec = ~v.sv; dst_vec = ~v.dv; vl = IW'(2);
    end
    for (int cyc = 0; cyc < 40; cyc++) begin
      if (mode == 2 && cyc == 1) begin
        src_base = 5'd13; dst_base = 5'd2; vl = IW'(1); start = 1'b1;
      end
      if (mode == 2 && cyc == 2) start = 1'b0;
      if (wr_en) begin
        if (n < exp_n) begin
          chk(cyc == n, "R10 back-to-back", cyc, n);
          chk(int'(src_offs) == exp_i[n], "R9 src_offs", int'(src_offs), exp_i[n]);
          chk(int'(dst_offs) == exp_j[n], "R9 dst_offs", int'(dst_offs), exp_j[n]);
          chk(int'(rd_addr) == ((int'(v.sb) + exp_i[n]) % 32), "R3 rd_addr",
              int'(rd_addr), (int'(v.sb) + exp_i[n]) % 32);
          chk(int'(wr_addr) == ((int'(v.db) + exp_j[n]) % 32), "R3 wr_addr",
              int'(wr_addr), (int'(v.db) + exp_j[n]) % 32);
        end
        n++;
      end
      if (done) begin
        dones++;
        chk(!wr_en, "R7 done without write", int'(wr_en), 0);
        @(negedge clk);
        chk(!done, "R7 done one cycle", int'(done), 0);
        chk(!wr_en, "R8 no second operation", int'(wr_en), 0);
        break;
      end
      @(negedge clk);
    end
    chk(dones == 1, "R7 done seen", dones, 1);
    chk(n == exp_n, "R6 copy count", n, exp_n);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!wr_en, "R1 wr_en", int'(wr_en), 0);
    chk(!done, "R1 done", int'(done), 0);
    chk(src_offs == '0, "R1 src_offs", int'(src_offs), 0);
    chk(dst_offs == '0, "R1 dst_offs", int'(dst_offs), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_en && !done, "R1 idle after release", int'(wr_en), 0);

    // Table walk: R2 R3 R4 R5 R6 R9 R10
    for (int t = 0; t < NV; t++) run_op(TBL[t], 0);

    // R5: broadcast reads the same register each time
    begin
      int same = 0;
      @(negedge clk);
      drive(TBL[1]);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 5; c++) begin
        if (wr_en && rd_addr == 5'd3) same++;
        @(negedge clk);
      end
      chk(same == 5, "R5 broadcast source fixed", same, 5);
      repeat (3) @(negedge clk);
    end

    // R4: extract with a scalar target issues one copy of source element 5
    run_op(TBL[6], 0);

    // R8: operands changed right after start are not used
    run_op(TBL[3], 1);
    run_op(TBL[0], 1);

    // R8: start while running is ignored
    run_op(TBL[0], 2);

    // R6: vl zero with scalar sides gives no write
    run_op('{5'd1, 5'd2, 1'b0, 1'b0, 8'hFF, 8'hFF, 4'd0, 4'd0}, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule